// File: doc/BRIEF.md
# Interleaved VLIW Clause Issue Engine

This block steps through one ALU clause: a contiguous run of five-slot VLIW bundles held in an instruction memory. It runs each bundle for a pair of thread batches. Every batch covers its elements in four lane-group phases. The engine interleaves the two batches cycle by cycle, so one bundle takes eight clocks. Within a bundle the order is batch 0 phase 0, batch 1 phase 0, batch 0 phase 1, and so on. A clause of N bundles therefore occupies the engine for exactly 8·N clocks, and no clock is lost to hazards.

No dependency checking happens in hardware. The instruction stream is assumed to be scheduled ahead of time. A slot result can reach the next bundle in two ways: through a per-slot forwarding register (the previous-vector value), or through four clause-scoped temporaries. Each batch/phase context keeps its own copy of both. General registers live outside the block. The engine drives one read address per slot and one write port per slot, and it shows the current batch and phase so the register file can select the right lane group. The slot arithmetic is a plain integer add, multiply or move, done modulo 2^DW.

Top module: `clause_engine`

## Requirements
- R1: After reset, busy and done are low, and no read enable or write enable is asserted.
- R2: A start seen while idle launches a clause at startAddr. The count field c (0 meaning one bundle, up to MAX_BUNDLES) gives c+1 bundles. busy stays high for exactly 8·(c+1) cycles, and imemAddr holds startAddr+k through all eight cycles of bundle k.
- R3: Inside a bundle, curBatch toggles every cycle, starting at 0. curPhase is the cycle index within the bundle divided by two (0..3).
- R4: done is a one-cycle pulse in the cycle right after the last cycle of the clause, and busy is low in that cycle.
- R5: A start asserted while busy is ignored: the running clause's length, addresses and results are unchanged.
- R6: Slot s (x=0, y=1, z=2, w=3, t=4) sits in bundle bits [20s+19:20s] with these fields: op [19:18] (0 none, 1 add, 2 multiply, 3 move A), aKind [17:16], aIdx [15:12], bKind [11:10], bIdx [9:6], dKind [5:4], dIdx [3:0]. Results wrap modulo 2^DW.
- R7: Operand kinds: 1 selects temporary idx[1:0], 2 selects the forwarded result of slot idx (an idx above 4 reads 0), and 3 is the immediate idx zero-extended. Kind 0 reads general register idx for operand A and reads zero for operand B.
- R8: The forwarded value of slot s is that slot's result in the previous bundle for the same batch and phase. A slot with op 0 forwards 0. Contexts never see each other's values.
- R9: dKind 2 writes temporary dIdx[1:0] of the current batch/phase. Operands always read values from before the bundle. When several slots write the same temporary, the highest slot index wins.
- R10: dKind 1 asserts the slot's write enable, with address dIdx and the result as data, in the same cycle. dKind 0 or 3 and op 0 never write. A read enable is asserted only for a non-none op whose aKind is 0.
- R11: Every clause start clears all temporaries and forwarded values to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a clause (taken only while idle) |
| startAddr | input | IA_W | Address of the first bundle |
| bundleCnt | input | CNT_W | Bundle count minus one |
| busy | output | 1 | Clause in progress |
| done | output | 1 | One-cycle end-of-clause pulse |
| imemAddr | output | IA_W | Instruction memory address |
| imemBundle | input | 100 | Bundle read combinationally at imemAddr |
| curBatch | output | 1 | Batch of the current cycle |
| curPhase | output | 2 | Lane-group phase of the current cycle |
| rfRdEn | output | 5 | Per-slot general register read enable |
| rfRdAddr | output | 20 | Per-slot read index, 4 bits per slot |
| rfRdData | input | 5·DW | Per-slot read data for the current batch/phase |
| rfWrEn | output | 5 | Per-slot write enable |
| rfWrAddr | output | 20 | Per-slot write index, 4 bits per slot |
| rfWrData | output | 5·DW | Per-slot write data |

## Verification
Hand-built clauses aim each slot at a single mechanism, and the register file is seeded with a different value in every batch/phase context. A forwarded value, a temporary carried across bundles, a same-bundle temporary collision and a read of an out-of-range forward slot each produce a distinct number, so a mixed-up context, a wrong priority or a stale value cannot hide. A second clause launched straight after the first separates clearing at start from retention. Clause lengths from one bundle up to the maximum check the cycle count, the address sequence and the batch/phase pattern. Random bundles over those lengths are compared against an arithmetic model of the final register contents, and a start injected mid-clause shows that a busy engine ignores it.

// File: rtl/clause_pkg.sv
package clause_pkg;
  localparam int NSLOTS   = 5;
  localparam int NCTX     = 8;   // 2 batches x 4 phases
  localparam int NTEMP    = 4;
  localparam int IDX_W    = 4;
  localparam int SLOT_W   = 20;
  localparam int BUNDLE_W = NSLOTS * SLOT_W;

  typedef enum logic [1:0] {OP_NONE, OP_ADD, OP_MUL, OP_MOV} opE;
  typedef enum logic [1:0] {SRC_GPR, SRC_TMP, SRC_FWD, SRC_IMM} srcE;
  typedef enum logic [1:0] {DST_FWD, DST_GPR, DST_TMP, DST_FWD_ALT} dstE;

  typedef struct packed {
    opE              op;
    srcE             aKind;
    logic [IDX_W-1:0] aIdx;
    srcE             bKind;
    logic [IDX_W-1:0] bIdx;
    dstE             dKind;
    logic [IDX_W-1:0] dIdx;
  } slotT;

  // strobes from sequencer to slot datapath
  typedef struct packed {
    logic       active;
    logic       clear;
    logic       batch;
    logic [1:0] phase;
  } strobeT;
endpackage

// File: rtl/clause_seq.sv
module clause_seq import clause_pkg::*; #(
  parameter int IA_W        = 10,
  parameter int MAX_BUNDLES = 128,
  localparam int CNT_W      = $clog2(MAX_BUNDLES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IA_W-1:0]  startAddr,
  input  logic [CNT_W-1:0] bundleCnt,
  output logic             busy,
  output logic             done,
  output logic [IA_W-1:0]  imemAddr,
  output strobeT           stb
);
  logic [IA_W-1:0]  baseAddr;
  logic [CNT_W-1:0] bundleIdx;
  logic [CNT_W-1:0] lastIdx;
  logic [2:0]       subCyc;   // {phase, batch}

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      baseAddr  <= '0;
      bundleIdx <= '0;
      lastIdx   <= '0;
      subCyc    <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          baseAddr  <= startAddr;
          lastIdx   <= bundleCnt;
          bundleIdx <= '0;
          subCyc    <= '0;
        end
      end else begin
        subCyc <= subCyc + 3'd1;
        if (subCyc == 3'd7) begin
          if (bundleIdx == lastIdx) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bundleIdx <= bundleIdx + 1'b1;
          end
        end
      end
    end
  end

  assign imemAddr = baseAddr + IA_W'(bundleIdx);

  always_comb begin
    stb.active = busy;
    stb.clear  = !busy && start;
    stb.batch  = subCyc[0];
    stb.phase  = subCyc[2:1];
  end
endmodule

// File: rtl/clause_slots.sv
module clause_slots import clause_pkg::*; #(
  parameter int DW = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobeT                    stb,
  input  logic [BUNDLE_W-1:0]       bundle,
  input  logic [NSLOTS*DW-1:0]      rdData,
  output logic [NSLOTS-1:0]         rdEn,
  output logic [NSLOTS*IDX_W-1:0]   rdAddr,
  output logic [NSLOTS-1:0]         wrEn,
  output logic [NSLOTS*IDX_W-1:0]   wrAddr,
  output logic [NSLOTS*DW-1:0]      wrData
);
  logic [DW-1:0] tmpR [NCTX][NTEMP];
  logic [DW-1:0] fwdR [NCTX][NSLOTS];
  logic [2:0]    ctx;
  slotT          sl   [NSLOTS];
  logic [DW-1:0] opA  [NSLOTS];
  logic [DW-1:0] opB  [NSLOTS];
  logic [DW-1:0] res  [NSLOTS];

  assign ctx = {stb.phase, stb.batch};

  function automatic logic [DW-1:0] fetchOp(input srcE kind, input logic [IDX_W-1:0] idx,
                                            input logic [DW-1:0] gprVal, input logic isA);
    case (kind)
      SRC_GPR: return isA ? gprVal : '0;
      SRC_TMP: return tmpR[ctx][idx[1:0]];
      SRC_FWD: return (idx < IDX_W'(NSLOTS)) ? fwdR[ctx][idx[2:0]] : '0;
      default: return DW'(idx);
    endcase
  endfunction

  always_comb begin
    for (int s = 0; s < NSLOTS; s++) begin
      sl[s]  = slotT'(bundle[s*SLOT_W +: SLOT_W]);
      opA[s] = fetchOp(sl[s].aKind, sl[s].aIdx, rdData[s*DW +: DW], 1'b1);
      opB[s] = fetchOp(sl[s].bKind, sl[s].bIdx, rdData[s*DW +: DW], 1'b0);
      case (sl[s].op)
        OP_ADD:  res[s] = opA[s] + opB[s];
        OP_MUL:  res[s] = opA[s] * opB[s];
        OP_MOV:  res[s] = opA[s];
        default: res[s] = '0;
      endcase
      rdEn[s] = stb.active && (sl[s].op != OP_NONE) && (sl[s].aKind == SRC_GPR);
      wrEn[s] = stb.active && (sl[s].op != OP_NONE) && (sl[s].dKind == DST_GPR);
      rdAddr[s*IDX_W +: IDX_W] = sl[s].aIdx;
      wrAddr[s*IDX_W +: IDX_W] = sl[s].dIdx;
      wrData[s*DW +: DW]       = res[s];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NCTX; c++) begin
        for (int t = 0; t < NTEMP; t++)  tmpR[c][t] <= '0;
        for (int s = 0; s < NSLOTS; s++) fwdR[c][s] <= '0;
      end
    end else if (stb.clear) begin
      for (int c = 0; c < NCTX; c++) begin
        for (int t = 0; t < NTEMP; t++)  tmpR[c][t] <= '0;
        for (int s = 0; s < NSLOTS; s++) fwdR[c][s] <= '0;
      end
    end else if (stb.active) begin
      for (int s = 0; s < NSLOTS; s++) fwdR[ctx][s] <= res[s];
      // ascending loop: the highest slot writing a temporary wins
      for (int s = 0; s < NSLOTS; s++)
        if (sl[s].op != OP_NONE && sl[s].dKind == DST_TMP)
          tmpR[ctx][sl[s].dIdx[1:0]] <= res[s];
    end
  end
endmodule

// File: rtl/clause_engine.sv
module clause_engine import clause_pkg::*; #(
  parameter int IA_W        = 10,
  parameter int DW          = 16,
  parameter int MAX_BUNDLES = 128,
  localparam int CNT_W      = $clog2(MAX_BUNDLES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [IA_W-1:0]         startAddr,
  input  logic [CNT_W-1:0]        bundleCnt,
  output logic                    busy,
  output logic                    done,
  output logic [IA_W-1:0]         imemAddr,
  input  logic [BUNDLE_W-1:0]     imemBundle,
  output logic                    curBatch,
  output logic [1:0]              curPhase,
  output logic [NSLOTS-1:0]       rfRdEn,
  output logic [NSLOTS*IDX_W-1:0] rfRdAddr,
  input  logic [NSLOTS*DW-1:0]    rfRdData,
  output logic [NSLOTS-1:0]       rfWrEn,
  output logic [NSLOTS*IDX_W-1:0] rfWrAddr,
  output logic [NSLOTS*DW-1:0]    rfWrData
);
  strobeT stb;

  clause_seq #(.IA_W(IA_W), .MAX_BUNDLES(MAX_BUNDLES)) uSeq (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .bundleCnt(bundleCnt), .busy(busy), .done(done), .imemAddr(imemAddr), .stb(stb)
  );

  clause_slots #(.DW(DW)) uSlots (
    .clk(clk), .rstN(rstN), .stb(stb), .bundle(imemBundle), .rdData(rfRdData),
    .rdEn(rfRdEn), .rdAddr(rfRdAddr), .wrEn(rfWrEn), .wrAddr(rfWrAddr), .wrData(rfWrData)
  );

  assign curBatch = stb.batch;
  assign curPhase = stb.phase;
endmodule

// File: rtl/clause_engine_chk.sv
module clause_engine_chk #(
  parameter int IA_W = 10
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            done,
  input logic [IA_W-1:0] imemAddr,
  input logic            curBatch,
  input logic [1:0]      curPhase,
  input logic [4:0]      rfWrEn,
  input logic [4:0]      rfRdEn
);
  logic            busyQ;
  logic            batchQ;
  logic [1:0]      phaseQ;
  logic [IA_W-1:0] addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      batchQ <= 1'b0;
      phaseQ <= '0;
      addrQ  <= '0;
    end else begin
      busyQ  <= busy;
      batchQ <= curBatch;
      phaseQ <= curPhase;
      addrQ  <= imemAddr;
    end
  end

  // R4
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !busy) |-> done);
  // R4
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R3
  batch_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busyQ) |-> (curBatch != batchQ));
  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busyQ && !batchQ) |-> (curPhase == phaseQ));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busyQ && !(batchQ && phaseQ == 2'd3)) |-> (imemAddr == addrQ));
  // R10
  no_idle_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|rfWrEn) |-> busy);
  // R10
  no_idle_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|rfRdEn) |-> busy);
endmodule

bind clause_engine clause_engine_chk #(.IA_W(IA_W)) uChk (.*);

// File: tb/sim_clause_engine.sv
module sim_clause_engine;
  localparam int CLK_P = 10;
  localparam int IA_W = 10;
  localparam int DW = 16;
  localparam int CNT_W = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [IA_W-1:0] startAddr = '0;
  logic [CNT_W-1:0] bundleCnt = '0;
  logic busy, done, curBatch;
  logic [1:0] curPhase;
  logic [IA_W-1:0] imemAddr;
  logic [99:0] imemBundle;
  logic [4:0] rfRdEn, rfWrEn;
  logic [19:0] rfRdAddr, rfWrAddr;
  logic [79:0] rfRdData, rfWrData;

  logic [99:0] imem [1024];
  logic [15:0] rf [128];
  logic [15:0] mRf [128];
  int nChecks = 0, nFail = 0, wrPulses = 0, rdPulses = 0;

  always #(CLK_P/2) clk = ~clk;

  clause_engine u0 (.*);

  function automatic int ri(input int b, input int p, input int r);
    return p*32 + b*16 + r;
  endfunction

  always_comb imemBundle = imem[imemAddr];
  always_comb
    for (int s = 0; s < 5; s++)
      rfRdData[s*16 +: 16] = rf[{curPhase, curBatch, rfRdAddr[s*4 +: 4]}];

  always @(posedge clk) begin
    for (int s = 0; s < 5; s++)
      if (rfWrEn[s]) rf[{curPhase, curBatch, rfWrAddr[s*4 +: 4]}] <= rfWrData[s*16 +: 16];
    wrPulses <= wrPulses + $countones(rfWrEn);
    rdPulses <= rdPulses + $countones(rfRdEn);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] mk(input int op, ak, ai, bk, bi, dk, di);
    return {2'(op), 2'(ak), 4'(ai), 2'(bk), 4'(bi), 2'(dk), 4'(di)};
  endfunction

  function automatic logic [15:0] pick(input int kind, input int idx, input logic [15:0] gpr,
                                       input bit isA, input logic [15:0] tv, input logic [15:0] fv);
    case (kind)
      0: return isA ? gpr : 16'd0;
      1: return tv;
      2: return (idx < 5) ? fv : 16'd0;
      default: return 16'(idx);
    endcase
  endfunction

  // arithmetic model of a clause on mRf
  task automatic modelRun(input int base, input int n);
    logic [15:0] tmp [8][4];
    logic [15:0] fwd [8][5];
    logic [15:0] res [5];
    for (int c = 0; c < 8; c++) begin
      for (int t = 0; t < 4; t++) tmp[c][t] = 0;
      for (int s = 0; s < 5; s++) fwd[c][s] = 0;
    end
    for (int k = 0; k < n; k++) begin
      for (int sub = 0; sub < 8; sub++) begin
        int b = sub % 2, p = sub / 2, c = p*2 + b;
        logic [99:0] bu = imem[base + k];
        for (int s = 0; s < 5; s++) begin
          logic [19:0] f = bu[s*20 +: 20];
          logic [15:0] a, bv;
          a  = pick(f[17:16], f[15:12], mRf[ri(b, p, f[15:12])], 1, tmp[c][f[13:12]],
                    fwd[c][f[14:12] % 5]);
          bv = pick(f[11:10], f[9:6], 16'd0, 0, tmp[c][f[7:6]], fwd[c][f[8:6] % 5]);
          case (f[19:18])
            1: res[s] = a + bv;
            2: res[s] = a * bv;
            3: res[s] = a;
            default: res[s] = 0;
          endcase
        end
        for (int s = 0; s < 5; s++) begin
          logic [19:0] f = bu[s*20 +: 20];
          fwd[c][s] = res[s];
          if (f[19:18] != 0 && f[5:4] == 1) mRf[ri(b, p, f[3:0])] = res[s];
          if (f[19:18] != 0 && f[5:4] == 2) tmp[c][f[1:0]] = res[s];
        end
      end
    end
  endtask

  task automatic initRf();
    for (int i = 0; i < 128; i++) rf[i] = 16'(i*37 + 11);
  endtask

  // runs a clause, checks length, address, batch/phase pattern and done pulse
  task automatic runClause(input int base, input int cnt, input bit inject, input string tag);
    int cyc = 0, addrBad = 0, patBad = 0;
    startAddr = IA_W'(base); bundleCnt = CNT_W'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && cyc < 5000) begin
      if (imemAddr != IA_W'(base + cyc/8)) addrBad++;
      if (curBatch != 1'(cyc % 2) || curPhase != 2'((cyc/2) % 4)) patBad++;
      cyc++;
      if (inject && cyc == 3) begin startAddr = '0; bundleCnt = 7'd5; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
    end
    chk(cyc == (cnt+1)*8, {tag, " R2 busy length"}, cyc, (cnt+1)*8);
    chk(addrBad == 0, {tag, " R2 address sequence errors"}, addrBad, 0);
    chk(patBad == 0, {tag, " R3 batch/phase pattern errors"}, patBad, 0);
    chk(done == 1'b1, {tag, " R4 done after last cycle"}, done, 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, {tag, " R4 done single pulse"}, done, 0);
  endtask

  task automatic cmpRf(input string tag);
    int bad = 0, first = -1;
    for (int i = 0; i < 128; i++)
      if (rf[i] !== mRf[i]) begin bad++; if (first < 0) first = i; end
    chk(bad == 0, {tag, " R6 R7 R8 R9 R10 model mismatch count"}, bad, 0);
    if (bad != 0) $display("  first mismatch idx %0d actual=%0d expected=%0d", first, rf[first], mRf[first]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) imem[i] = '0;
    initRf();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1 busy/done low in reset", {busy, done}, 0);
    chk(rfWrEn == 0 && rfRdEn == 0, "R1 no enables in reset", {rfWrEn, rfRdEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && rfWrEn == 0, "R1 idle after reset", busy, 0);

    // directed clause: forwarding, temporaries, writes
    imem[0] = {mk(1,0,3,3,1,1,9),   // t: g3+1 -> g9
               20'd0,               // w: none
               mk(1,3,5,0,0,2,1),   // z: 5+0 -> T1 (wins)
               mk(2,0,2,3,2,2,1),   // y: g2*2 -> T1
               mk(1,0,1,3,3,0,0)};  // x: g1+3 -> forward only
    imem[1] = {mk(2,0,2,3,3,1,10),  // t: g2*3 -> g10
               mk(3,2,6,0,0,1,8),   // w: fwd slot 6 -> g8
               mk(3,2,3,0,0,1,7),   // z: fwd of none slot w -> g7
               mk(3,1,1,0,0,1,6),   // y: T1 -> g6
               mk(3,2,0,0,0,1,5)};  // x: fwd x -> g5
    initRf(); wrPulses = 0; rdPulses = 0;
    runClause(0, 1, 0, "directed");
    begin
      int bad8 = 0, bad5 = 0, bad6 = 0, bad7 = 0, bad9 = 0, bad10 = 0;
      for (int b = 0; b < 2; b++)
        for (int p = 0; p < 4; p++) begin
          if (rf[ri(b,p,5)]  != 16'(ri(b,p,1)*37 + 11 + 3)) bad5++;
          if (rf[ri(b,p,6)]  != 16'd5) bad6++;
          if (rf[ri(b,p,7)]  != 16'd0) bad7++;
          if (rf[ri(b,p,8)]  != 16'd0) bad8++;
          if (rf[ri(b,p,9)]  != 16'(ri(b,p,3)*37 + 11 + 1)) bad9++;
          if (rf[ri(b,p,10)] != 16'((ri(b,p,2)*37 + 11) * 3)) bad10++;
        end
      chk(bad5 == 0, "R8 forwarded slot x per context", bad5, 0);
      chk(bad6 == 0, "R9 later slot wins temporary", bad6, 0);
      chk(bad7 == 0, "R8 none slot forwards zero", bad7, 0);
      chk(bad8 == 0, "R7 forward index above 4 reads zero", bad8, 0);
      chk(bad9 == 0, "R10 same-cycle register write", bad9, 0);
      chk(bad10 == 0, "R6 multiply with immediate", bad10, 0);
    end
    chk(wrPulses == 48, "R10 write enable count", wrPulses, 48);
    chk(rdPulses == 32, "R10 read enable count", rdPulses, 32);

    // R11: new clause sees cleared temporaries and forwards
    imem[20] = {60'd0, mk(3,2,1,0,0,1,12), mk(3,1,1,0,0,1,11)};
    runClause(20, 0, 0, "clear");
    begin
      int badC = 0;
      for (int i = 0; i < 8; i++)
        if (rf[(i/2)*32 + (i%2)*16 + 11] != 0 || rf[(i/2)*32 + (i%2)*16 + 12] != 0) badC++;
      chk(badC == 0, "R11 temporaries and forwards cleared at start", badC, 0);
    end

    // random clauses over several lengths, compared with the model
    foreach (imem[i]) if (i >= 100 && i < 400)
      for (int s = 0; s < 5; s++) imem[i][s*20 +: 20] = 20'($urandom);
    begin
      int lens [5] = '{0, 1, 2, 4, 127};
      for (int j = 0; j < 5; j++) begin
        initRf();
        for (int i = 0; i < 128; i++) mRf[i] = rf[i];
        modelRun(100 + j, lens[j] + 1);
        runClause(100 + j, lens[j], 0, $sformatf("random len %0d", lens[j] + 1));
        cmpRf($sformatf("random len %0d", lens[j] + 1));
      end
    end

    // R5: start during a clause is ignored
    initRf();
    for (int i = 0; i < 128; i++) mRf[i] = rf[i];
    modelRun(300, 3);
    runClause(300, 2, 1, "R5 start while busy");
    cmpRf("R5 start while busy");

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule